// File: doc/BRIEF.md
# Strided Memory Access Engine

This block is a word-addressed on-chip memory with a valid/ready command front end. A client sends operations on an address channel that carries a two-bit operation code. Stride, beat count and write data each arrive on their own valid/ready channel. Every result leaves on a single valid/ready response channel, and that includes the acknowledgement for each write.

The block serves four kinds of command: single reads, single writes, burst reads and burst writes. A burst command latches a start address, a signed stride and a beat count. The engine then steps through the addresses without further help from the client. It refuses new commands until the remaining count reaches zero.

The response channel is a single register. It is loaded from a synchronous read of the array, or with a zero token when the operation is a write. Its contents hold until the consumer accepts them.

Top module: `strided_mem`

## Requirements
- R1: Single read. Operation code 2'b00 is a single read. It is accepted only when the response register is empty or is being drained in the same cycle. The stored word appears on `rsp_data` with `rsp_valid` high in the cycle after acceptance.
- R2: Single write. Operation code 2'b01 is a single write. The address and the write data are consumed in the same cycle, and only when `wdata_valid` is high and the response register is free. The word is stored and a response of value 0 follows in the next cycle.
- R3: Burst command acceptance. Operation code 2'b10 is a burst read and 2'b11 is a burst write. A burst command is accepted only when both `stride_valid` and `count_valid` are high. The command, stride and count are consumed in the same cycle, so `stride_ready` and `count_ready` only ever rise together with `cmd_ready`.
- R4: Burst addressing. Each burst beat decrements the remaining count by one. It moves the current address by the stride, which is a signed two's-complement value, and the address wraps modulo the memory depth.
- R5: Busy blocking. While a burst has beats remaining, `cmd_ready` stays low and the address channel is ignored.
- R6: Burst write beats. A burst write beat happens only when write data is valid and the response register is free. Each beat stores the word and emits a response of 0.
- R7: Burst read beats. A burst read beat happens whenever the response register is free, and it emits the word at the current address.
- R8: Zero-count bursts. A burst with a count of 0 completes at acceptance. It produces no response, takes no write data and leaves the engine idle.
- R9: Response hold. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` stays high and `rsp_data` stays unchanged.
- R10: Reset state. After reset no response is pending, no burst is active, and none of the ready outputs is high while no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command consumed this cycle |
| cmd_op | input | 2 | Operation: 00 read, 01 write, 10 burst read, 11 burst write |
| cmd_addr | input | AW | Word address, or burst start address |
| stride_valid | input | 1 | Stride present |
| stride_ready | output | 1 | Stride consumed |
| stride_data | input | AW | Signed burst stride |
| count_valid | input | 1 | Count present |
| count_ready | output | 1 | Count consumed |
| count_data | input | CW | Burst beat count |
| wdata_valid | input | 1 | Write data present |
| wdata_ready | output | 1 | Write data consumed |
| wdata | input | DW | Write data word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer accepts response |
| rsp_data | output | DW | Read word, or 0 for a write acknowledgement |

## Verification
The checker watches several rules on every cycle:
- the response register holding steady while it is stalled;
- the zero token following every write-data transfer;
- stride and count being taken only together with a burst command;
- commands being blocked while a count remains;
- the count stepping down by one per write beat;
- zero-count bursts leaving the engine idle.

Some things only the bench scenarios can show. These are the actual word returned for each address, the wrap of negative and positive strides around the array, and that a command presented during a burst is served afterwards and not earlier. The bench shows them by comparing every response against a behavioural memory model while the response consumer stalls at random.

// File: rtl/strided_mem.sv
module strided_mem #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic          stride_valid,
  output logic          stride_ready,
  input  logic [AW-1:0] stride_data,
  input  logic          count_valid,
  output logic          count_ready,
  input  logic [CW-1:0] count_data,
  input  logic          wdata_valid,
  output logic          wdata_ready,
  input  logic [DW-1:0] wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_RD = 2'b00;
  localparam logic [1:0] OP_WR = 2'b01;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] cur_addr, cur_stride;
  logic [CW-1:0] remain;
  logic          burst_wr;

  logic busy, out_free, sgl_rd, sgl_wr, bst_go, beat_rd, beat_wr, mem_we, emit;
  logic [AW-1:0] mem_addr;

  assign busy     = |remain;
  assign out_free = !rsp_valid || rsp_ready;
  assign sgl_rd   = !busy && cmd_valid && cmd_op == OP_RD && out_free;
  assign sgl_wr   = !busy && cmd_valid && cmd_op == OP_WR && wdata_valid && out_free;
  assign bst_go   = !busy && cmd_valid && cmd_op[1] && stride_valid && count_valid;
  assign beat_wr  = busy && burst_wr && wdata_valid && out_free;
  assign beat_rd  = busy && !burst_wr && out_free;

  assign mem_we   = sgl_wr || beat_wr;
  assign mem_addr = busy ? cur_addr : cmd_addr;
  assign emit     = sgl_rd || sgl_wr || beat_rd || beat_wr;

  assign cmd_ready    = sgl_rd || sgl_wr || bst_go;
  assign stride_ready = bst_go;
  assign count_ready  = bst_go;
  assign wdata_ready  = mem_we;

  always_ff @(posedge clk)
    if (mem_we) mem[mem_addr] <= wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (emit) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem_we ? '0 : mem[mem_addr];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain     <= '0;
      cur_addr   <= '0;
      cur_stride <= '0;
      burst_wr   <= 1'b0;
    end else if (bst_go) begin
      remain     <= count_data;
      cur_addr   <= cmd_addr;
      cur_stride <= stride_data;
      burst_wr   <= cmd_op[0];
    end else if (beat_rd || beat_wr) begin
      remain     <= remain - 1'b1;
      cur_addr   <= cur_addr + cur_stride;
    end
  end
endmodule

module strided_mem_chk #(
  parameter int DW = 16,
  parameter int AW = 6,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic          stride_ready,
  input logic          count_ready,
  input logic [CW-1:0] count_data,
  input logic          wdata_valid,
  input logic          wdata_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic [CW-1:0] remain
);
  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R2
  wr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_valid && wdata_ready |=> rsp_valid && rsp_data == '0);
  // R3
  burst_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stride_ready || count_ready |-> stride_ready && count_ready && cmd_ready && cmd_op[1]);
  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remain != '0 |-> !cmd_ready);
  // R1
  rd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'b00 |=> rsp_valid);
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remain != '0 && wdata_valid && wdata_ready |=> remain == CW'($past(remain) - 1'b1));
  // R8
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op[1] && count_data == '0 |=> remain == '0 && !wdata_ready);
endmodule

bind strided_mem strided_mem_chk #(.DW(DW), .AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .stride_ready(stride_ready), .count_ready(count_ready),
  .count_data(count_data), .wdata_valid(wdata_valid), .wdata_ready(wdata_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .remain(remain)
);

// File: tb/strided_mem_bench.sv
`timescale 1ns/1ps
module strided_mem_bench;
  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [5:0] cmd_addr = 0, stride_data = 0;
  logic stride_valid = 0, stride_ready, count_valid = 0, count_ready;
  logic [7:0] count_data = 0;
  logic wdata_valid = 0, wdata_ready;
  logic [15:0] wdata;
  logic rsp_valid, rsp_ready = 0;
  logic [15:0] rsp_data;

  always #10 clk = ~clk;

  strided_mem u_strided_mem (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  int wseq = 0;
  bit wtaken = 0;
  int rdy_mode = 0;
  logic [7:0] lfsr = 8'h5A;
  assign wdata = 16'(wseq * 37 + 11);

  logic [15:0] mm [64];
  logic [15:0] qd [$];
  string qt [$];
  int wb_rem = 0, wb_addr = 0, wb_s = 0;
  bit prev_stall = 0, mon_on = 0;
  logic [15:0] prev_data;

  function automatic int wrp(int x); return ((x % 64) + 64) % 64; endfunction
  function automatic int sx(logic [5:0] s); return s[5] ? int'(s) - 64 : int'(s); endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (wtaken) wseq++;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rsp_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? 1'b0 : lfsr[0];
  end

  always @(negedge clk) begin
    wtaken = wdata_valid && wdata_ready;
    if (mon_on) begin
      if (prev_stall) check(rsp_valid && rsp_data == prev_data, "R9", rsp_data, prev_data);
      prev_stall = rsp_valid && !rsp_ready;
      prev_data = rsp_data;
      if (rsp_valid && rsp_ready) begin
        if (qd.size() == 0) check(0, "R7 unexpected response", rsp_data, 0);
        else begin
          automatic logic [15:0] e = qd.pop_front();
          automatic string t = qt.pop_front();
          check(rsp_data == e, t, rsp_data, e);
        end
      end
      if (wb_rem > 0) begin
        check(!cmd_ready, "R5", cmd_ready, 0);
        if (wdata_valid && wdata_ready) begin
          mm[wb_addr] = wdata; qd.push_back(16'h0); qt.push_back("R6");
          wb_addr = wrp(wb_addr + wb_s); wb_rem--;
        end
      end
      if (cmd_valid && cmd_ready) begin
        case (cmd_op)
          2'b00: begin qd.push_back(mm[cmd_addr]); qt.push_back("R1"); end
          2'b01: begin mm[cmd_addr] = wdata; qd.push_back(16'h0); qt.push_back("R2"); end
          2'b10: for (int k = 0; k < int'(count_data); k++) begin
                   qd.push_back(mm[wrp(int'(cmd_addr) + k * sx(stride_data))]);
                   qt.push_back(stride_data == 6'd1 ? "R7" : "R4");
                 end
          default: begin wb_rem = count_data; wb_addr = cmd_addr; wb_s = sx(stride_data); end
        endcase
      end
    end
  end

  task automatic send_cmd(logic [1:0] op, logic [5:0] a, logic [5:0] s, logic [7:0] n);
    @(posedge clk); #3;
    cmd_valid = 1; cmd_op = op; cmd_addr = a;
    if (op[1]) begin stride_valid = 1; stride_data = s; count_valid = 1; count_data = n; end
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #3;
    cmd_valid = 0; stride_valid = 0; count_valid = 0;
  endtask

  task automatic drain();
    while (qd.size() != 0 || wb_rem != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    @(negedge clk);
    // R10
    check(!rsp_valid && !cmd_ready && !stride_ready && !count_ready && !wdata_ready,
          "R10", {rsp_valid, cmd_ready, stride_ready, count_ready, wdata_ready}, 0);
    mon_on = 1;

    // R6: fill whole array by burst write, stride 1
    wdata_valid = 1;
    send_cmd(2'b11, 6'd0, 6'd1, 8'd64);
    drain();

    // R7: burst read with random back-pressure
    rdy_mode = 2;
    send_cmd(2'b10, 6'd0, 6'd1, 8'd8);
    drain();

    // R4: negative stride wrapping below zero
    send_cmd(2'b10, 6'd2, 6'h3D, 8'd10);
    drain();

    // R4: burst write stride 5 across the top, then read back with same pattern
    send_cmd(2'b11, 6'd60, 6'd5, 8'd6);
    drain();
    send_cmd(2'b10, 6'd60, 6'd5, 8'd6);
    drain();
    rdy_mode = 0;

    // R2: single write waits for data, then single read returns it
    wdata_valid = 0;
    @(posedge clk); #3;
    cmd_valid = 1; cmd_op = 2'b01; cmd_addr = 6'd5;
    repeat (4) begin
      @(negedge clk);
      check(!cmd_ready && !wdata_ready, "R2 no data", cmd_ready, 0);
    end
    @(posedge clk); #3; wdata_valid = 1;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #3; cmd_valid = 0; wdata_valid = 0;
    send_cmd(2'b00, 6'd5, 6'd0, 8'd0);
    drain();

    // R3: burst with count missing is not taken
    @(posedge clk); #3;
    cmd_valid = 1; cmd_op = 2'b10; cmd_addr = 6'd3; stride_valid = 1; stride_data = 6'd1;
    repeat (3) begin
      @(negedge clk);
      check(!cmd_ready && !stride_ready && !count_ready, "R3", {cmd_ready, stride_ready}, 0);
    end
    @(posedge clk); #3; count_valid = 1; count_data = 8'd3;
    do @(negedge clk); while (!cmd_ready);
    check(stride_ready && count_ready, "R3 together", {stride_ready, count_ready}, 3);
    @(posedge clk); #3; cmd_valid = 0; stride_valid = 0; count_valid = 0;
    drain();

    // R8: zero-count burst write takes no data and yields no response
    wdata_valid = 1;
    send_cmd(2'b11, 6'd7, 6'd1, 8'd0);
    repeat (3) begin
      @(negedge clk);
      check(!wdata_ready && !rsp_valid, "R8", {wdata_ready, rsp_valid}, 0);
    end
    wdata_valid = 0;
    send_cmd(2'b00, 6'd7, 6'd0, 8'd0);
    drain();

    // R5: a command arriving during a stalled burst waits until it ends
    rdy_mode = 1;
    send_cmd(2'b10, 6'd10, 6'd1, 8'd4);
    cmd_valid = 1; cmd_op = 2'b00; cmd_addr = 6'd20;
    repeat (5) begin
      @(negedge clk);
      check(!cmd_ready, "R5 stalled burst", cmd_ready, 0);
    end
    rdy_mode = 0;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #3; cmd_valid = 0;
    drain();

    // R1: single read is held off while the response register is full
    rdy_mode = 1;
    send_cmd(2'b00, 6'd1, 6'd0, 8'd0);
    cmd_valid = 1; cmd_op = 2'b00; cmd_addr = 6'd2;
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid && !cmd_ready, "R1 full", {rsp_valid, cmd_ready}, 2);
    end
    rdy_mode = 0;
    do @(negedge clk); while (!cmd_ready);
    @(posedge clk); #3; cmd_valid = 0;
    drain();

    check(qd.size() == 0, "R7 leftover", qd.size(), 0);
    finish_run();
  end
endmodule